// File: doc/BRIEF.md
# Operand Shifter with Carry Output

This block forms the second operand of a 32-bit RISC arithmetic unit together with the carry that a shift produces. It is purely combinational. A register value can be shifted left, shifted right logically or arithmetically, or rotated. The shift distance comes either from a 5-bit field of the instruction or from the bottom byte of a second register. A separate constant mode instead takes an 8-bit literal and rotates it right by twice a 4-bit field.

Some immediate encodings with a distance of zero carry a special meaning. A logical or arithmetic right shift written with distance 0 shifts by the full word. A rotate written with distance 0 rotates the word one place through the carry flag, which gives a 33-bit rotate. A left shift written with distance 0 passes both the operand and the carry through unchanged. A distance taken from a register uses all eight bits. The ALU, the flag register and the instruction decoder are separate blocks.

Top module: `operand_shifter`

## Requirements
- R1: With the immediate distance and kind=0 (left shift), a distance n from 1 to 31 moves the operand n places towards the MSB with zero fill. carryOut is operand bit 32-n.
- R2: With the immediate distance, kind=0 and immAmt=0, opOut equals opIn and carryOut equals carryIn.
- R3: With kind=1 (logical right), an immediate n from 1 to 31 shifts with zero fill and carryOut is operand bit n-1. immAmt=0 gives a zero result, and carryOut is operand bit 31.
- R4: With kind=2 (arithmetic right), an immediate n from 1 to 31 fills the vacated bits with operand bit 31 and carryOut is operand bit n-1. immAmt=0 sets every result bit and carryOut to operand bit 31.
- R5: With kind=3 (rotate right), an immediate n from 1 to 31 rotates the operand right by n. carryOut equals result bit 31.
- R6: With kind=3 and immAmt=0, opOut is {carryIn, opIn[31:1]} and carryOut is opIn[0].
- R7: When amtFromReg=1, the distance is regAmt (8 bits) and immAmt has no effect. For every kind, regAmt=0 leaves opOut equal to opIn and carryOut equal to carryIn.
- R8: Register distances of 32 or more saturate. A left shift by 32 gives 0 with carry from bit 0, and a logical right shift by 32 gives 0 with carry from bit 31. Above 32 both give 0 with carry 0. An arithmetic shift of 32 or more fills the result and carryOut with bit 31. A rotate uses the distance modulo 32; a nonzero multiple of 32 returns opIn with carryOut equal to bit 31.
- R9: With constMode=1, opOut is constVal zero-extended to 32 bits and rotated right by 2*constRot. opIn, kind and both distances have no effect. carryOut is result bit 31 when constRot is nonzero, and carryIn when constRot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 32 | Register value to shift |
| kind | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amtFromReg | input | 1 | 1 selects regAmt as the distance, 0 selects immAmt |
| immAmt | input | 5 | Immediate shift distance field |
| regAmt | input | 8 | Bottom byte of the distance register |
| carryIn | input | 1 | Current carry flag |
| constMode | input | 1 | 1 selects the rotated 8-bit constant form |
| constVal | input | 8 | 8-bit literal for constant mode |
| constRot | input | 4 | Rotate field for constant mode (rotate by twice this value) |
| opOut | output | 32 | Shifted operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The checker assumes that every input is a known value once driven and that all inputs of one operation change together. Its results are therefore read only after the combinational paths have settled. The bench changes all inputs on one clock edge and samples on the opposite edge. Register distances are drawn with extra weight on 0, 31, 32, 33, multiples of 32 and 255, so that the saturation and modulo rules come up often. Immediate fields of zero are forced for each kind in turn, so that every reinterpreted encoding is reached alongside ordinary distances.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int unsigned SHF_DATA_W    = 32;
  localparam int unsigned SHF_AMT_W     = 5;
  localparam int unsigned SHF_REG_AMT_W = 8;
  localparam int unsigned SHF_CONST_W   = 8;
  localparam int unsigned SHF_ROT_W     = 4;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shiftKind_t;

  // Strobes from the decode side to the datapath
  typedef struct packed {
    logic       selConst;   // operand source is the zero-extended literal
    logic       passThru;   // operand and carry unchanged
    logic       rrx;        // one-place rotate through carry
    logic       fullWidth;  // distance equals the word width (or ROR multiple of it)
    logic       beyond;     // distance larger than the word width
    shiftKind_t kind;
  } shfStrobe_t;

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int unsigned AMT_W     = SHF_AMT_W,
  parameter int unsigned REG_AMT_W = SHF_REG_AMT_W,
  parameter int unsigned ROT_W     = SHF_ROT_W
) (
  input  shiftKind_t           kind,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     immAmt,
  input  logic [REG_AMT_W-1:0] regAmt,
  input  logic                 constMode,
  input  logic [ROT_W-1:0]     constRot,
  output shfStrobe_t           strobe,
  output logic [AMT_W-1:0]     amt
);

  localparam int unsigned FULL = 1 << AMT_W;
  localparam logic [REG_AMT_W-1:0] FULL_REG = REG_AMT_W'(FULL);

  logic [AMT_W-1:0] regLow;
  assign regLow = regAmt[AMT_W-1:0];

  always_comb begin
    strobe      = '0;
    strobe.kind = kind;
    amt         = '0;
    if (constMode) begin
      strobe.selConst = 1'b1;
      strobe.kind     = SH_ROR;
      amt             = AMT_W'({constRot, 1'b0});
      strobe.passThru = (constRot == '0);
    end else if (!amtFromReg) begin
      amt = immAmt;
      if (immAmt == '0) begin
        unique case (kind)
          SH_LSL:         strobe.passThru  = 1'b1;
          SH_LSR, SH_ASR: strobe.fullWidth = 1'b1;
          SH_ROR:         strobe.rrx       = 1'b1;
          default:        strobe.passThru  = 1'b1;
        endcase
      end
    end else begin
      amt = regLow;
      if (regAmt == '0) begin
        strobe.passThru = 1'b1;
      end else if (kind == SH_ROR) begin
        strobe.fullWidth = (regLow == '0);
      end else if (regAmt == FULL_REG) begin
        strobe.fullWidth = 1'b1;
      end else if (regAmt > FULL_REG) begin
        strobe.beyond = 1'b1;
      end
    end
  end

endmodule

// File: rtl/shf_dpath.sv
module shf_dpath
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W  = SHF_DATA_W,
  parameter int unsigned AMT_W   = SHF_AMT_W,
  parameter int unsigned CONST_W = SHF_CONST_W
) (
  input  shfStrobe_t         strobe,
  input  logic [AMT_W-1:0]   amt,
  input  logic [DATA_W-1:0]  opIn,
  input  logic [CONST_W-1:0] constVal,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  opOut,
  output logic               carryOut
);

  localparam int unsigned STAGES = AMT_W;
  localparam int unsigned MSB    = DATA_W - 1;

  logic [DATA_W-1:0] src;
  logic [AMT_W-1:0]  rotAmt;
  logic              signBit;
  logic [DATA_W-1:0] rightMask;
  logic [DATA_W-1:0] leftMask;
  logic [DATA_W-1:0] stg [0:STAGES];
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] normRes;
  logic              normCarry;

  assign src       = strobe.selConst ? DATA_W'(constVal) : opIn;
  assign signBit   = src[MSB];
  // A left shift by n is a right rotate by the word width minus n
  assign rotAmt    = (strobe.kind == SH_LSL) ? (AMT_W'(0) - amt) : amt;
  assign rightMask = {DATA_W{1'b1}} >> amt;
  assign leftMask  = {DATA_W{1'b1}} << amt;

  assign stg[0] = src;
  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    localparam int unsigned STEP = 1 << i;
    assign stg[i+1] = rotAmt[i] ? {stg[i][STEP-1:0], stg[i][DATA_W-1:STEP]} : stg[i];
  end
  assign rotated = stg[STAGES];

  // Ordinary distances 1 .. width-1; the last bit shifted out lands at bit 0
  // after a left rotate and at the MSB after a right rotate.
  always_comb begin
    unique case (strobe.kind)
      SH_LSL: begin
        normRes   = rotated & leftMask;
        normCarry = rotated[0];
      end
      SH_LSR: begin
        normRes   = rotated & rightMask;
        normCarry = rotated[MSB];
      end
      SH_ASR: begin
        normRes   = (rotated & rightMask) | (signBit ? ~rightMask : '0);
        normCarry = rotated[MSB];
      end
      default: begin
        normRes   = rotated;
        normCarry = rotated[MSB];
      end
    endcase
  end

  always_comb begin
    opOut    = normRes;
    carryOut = normCarry;
    if (strobe.passThru) begin
      opOut    = src;
      carryOut = carryIn;
    end else if (strobe.rrx) begin
      opOut    = {carryIn, src[MSB:1]};
      carryOut = src[0];
    end else if (strobe.fullWidth) begin
      unique case (strobe.kind)
        SH_LSL: begin
          opOut    = '0;
          carryOut = src[0];
        end
        SH_LSR: begin
          opOut    = '0;
          carryOut = signBit;
        end
        SH_ASR: begin
          opOut    = {DATA_W{signBit}};
          carryOut = signBit;
        end
        default: begin
          opOut    = src;
          carryOut = signBit;
        end
      endcase
    end else if (strobe.beyond) begin
      if (strobe.kind == SH_ASR) begin
        opOut    = {DATA_W{signBit}};
        carryOut = signBit;
      end else begin
        opOut    = '0;
        carryOut = 1'b0;
      end
    end
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W    = SHF_DATA_W,
  parameter int unsigned AMT_W     = SHF_AMT_W,
  parameter int unsigned REG_AMT_W = SHF_REG_AMT_W,
  parameter int unsigned CONST_W   = SHF_CONST_W,
  parameter int unsigned ROT_W     = SHF_ROT_W
) (
  input  logic [DATA_W-1:0]    opIn,
  input  logic [1:0]           kind,
  input  logic                 amtFromReg,
  input  logic [AMT_W-1:0]     immAmt,
  input  logic [REG_AMT_W-1:0] regAmt,
  input  logic                 carryIn,
  input  logic                 constMode,
  input  logic [CONST_W-1:0]   constVal,
  input  logic [ROT_W-1:0]     constRot,
  output logic [DATA_W-1:0]    opOut,
  output logic                 carryOut
);

  shfStrobe_t       strobe;
  logic [AMT_W-1:0] amt;

  shf_ctrl #(
    .AMT_W    (AMT_W),
    .REG_AMT_W(REG_AMT_W),
    .ROT_W    (ROT_W)
  ) ctrl_i (
    .kind      (shiftKind_t'(kind)),
    .amtFromReg(amtFromReg),
    .immAmt    (immAmt),
    .regAmt    (regAmt),
    .constMode (constMode),
    .constRot  (constRot),
    .strobe    (strobe),
    .amt       (amt)
  );

  shf_dpath #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .CONST_W(CONST_W)
  ) dpath_i (
    .strobe  (strobe),
    .amt     (amt),
    .opIn    (opIn),
    .constVal(constVal),
    .carryIn (carryIn),
    .opOut   (opOut),
    .carryOut(carryOut)
  );

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W    = SHF_DATA_W,
  parameter int unsigned AMT_W     = SHF_AMT_W,
  parameter int unsigned REG_AMT_W = SHF_REG_AMT_W,
  parameter int unsigned CONST_W   = SHF_CONST_W,
  parameter int unsigned ROT_W     = SHF_ROT_W
) (
  input logic [DATA_W-1:0]    opIn,
  input logic [1:0]           kind,
  input logic                 amtFromReg,
  input logic [AMT_W-1:0]     immAmt,
  input logic [REG_AMT_W-1:0] regAmt,
  input logic                 carryIn,
  input logic                 constMode,
  input logic [CONST_W-1:0]   constVal,
  input logic [ROT_W-1:0]     constRot,
  input logic [DATA_W-1:0]    opOut,
  input logic                 carryOut
);

  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [REG_AMT_W-1:0] FULL_REG = REG_AMT_W'(1 << AMT_W);

  logic immSel;
  assign immSel = !constMode && !amtFromReg && (immAmt == '0);

  always_comb begin
    if (immSel && kind == 2'd0) begin
      a_r2_lsl_zero_keeps: assert (opOut == opIn && carryOut == carryIn);
    end
    if (immSel && kind == 2'd1) begin
      a_r3_lsr_zero_full: assert (opOut == '0 && carryOut == opIn[MSB]);
    end
    if (immSel && kind == 2'd2) begin
      a_r4_asr_zero_sign: assert ($countones({opOut, carryOut}) == (opIn[MSB] ? DATA_W + 1 : 0));
    end
    if (immSel && kind == 2'd3) begin
      a_r6_rrx_shape: assert (opOut == {carryIn, opIn[MSB:1]} && carryOut == opIn[0]);
    end
    if (!constMode && amtFromReg && regAmt == '0) begin
      a_r7_reg_zero_keeps: assert (opOut == opIn && carryOut == carryIn);
    end
    if (!constMode && amtFromReg && regAmt > FULL_REG && (kind == 2'd0 || kind == 2'd1)) begin
      a_r8_beyond_clears: assert (opOut == '0 && !carryOut);
    end
    if (constMode && constRot == '0) begin
      a_r9_const_norot: assert (opOut == DATA_W'(constVal) && carryOut == carryIn);
    end
    if (constMode && constRot != '0) begin
      a_r9_const_carry: assert (carryOut == opOut[MSB] && $countones(opOut) == $countones(constVal));
    end
  end

endmodule

bind operand_shifter operand_shifter_chk #(
  .DATA_W   (DATA_W),
  .AMT_W    (AMT_W),
  .REG_AMT_W(REG_AMT_W),
  .CONST_W  (CONST_W),
  .ROT_W    (ROT_W)
) chk_i (.*);

// File: tb/operand_shifter_tb_top.sv
`timescale 1ns/1ps
module operand_shifter_tb_top;

  logic        clk = 1'b0;
  logic [31:0] opIn = '0;
  logic [1:0]  kind = '0;
  logic        amtFromReg = 1'b0;
  logic [4:0]  immAmt = '0;
  logic [7:0]  regAmt = '0;
  logic        carryIn = 1'b0;
  logic        constMode = 1'b0;
  logic [7:0]  constVal = '0;
  logic [3:0]  constRot = '0;
  logic [31:0] opOut;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  operand_shifter dut_i (
    .opIn(opIn), .kind(kind), .amtFromReg(amtFromReg), .immAmt(immAmt),
    .regAmt(regAmt), .carryIn(carryIn), .constMode(constMode),
    .constVal(constVal), .constRot(constRot), .opOut(opOut), .carryOut(carryOut)
  );

  // Bit-serial reference: one place per step, carry is the last bit moved out
  function automatic logic [32:0] refModel(
    input logic [31:0] x, input logic [1:0] k, input logic fromReg,
    input logic [4:0] ia, input logic [7:0] ra, input logic cin,
    input logic cm, input logic [7:0] cv, input logic [3:0] cr);
    logic [31:0] r;
    logic        c;
    logic [1:0]  kk;
    int          n;
    r = x; c = cin; kk = k; n = 0;
    if (cm) begin
      r = {24'b0, cv}; kk = 2'd3; n = 2 * int'(cr);
    end else if (!fromReg) begin
      n = int'(ia);
      if (ia == 5'd0) begin
        if (k == 2'd1 || k == 2'd2) n = 32;
        else if (k == 2'd3) return {x[0], cin, x[31:1]};
      end
    end else begin
      n = int'(ra);
    end
    for (int i = 0; i < n; i++) begin
      case (kk)
        2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {c, r};
  endfunction

  function automatic string reqOf(
    input logic [1:0] k, input logic fromReg, input logic [4:0] ia,
    input logic [7:0] ra, input logic cm);
    if (cm) return "R9";
    if (fromReg) begin
      if (ra == 8'd0) return "R7";
      if (ra >= 8'd32) return "R8";
    end else if (ia == 5'd0) begin
      case (k)
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R6";
      endcase
    end
    case (k)
      2'd0: return "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runOne(
    input logic [31:0] x, input logic [1:0] k, input logic fromReg,
    input logic [4:0] ia, input logic [7:0] ra, input logic cin,
    input logic cm, input logic [7:0] cv, input logic [3:0] cr, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    opIn = x; kind = k; amtFromReg = fromReg; immAmt = ia; regAmt = ra;
    carryIn = cin; constMode = cm; constVal = cv; constRot = cr;
    exp = refModel(x, k, fromReg, ia, ra, cin, cm, cv, cr);
    @(negedge clk);
    checks++;
    if ({carryOut, opOut} !== exp) begin
      fails++;
      $display("FAIL %s: kind=%0d reg=%0b imm=%0d regAmt=%0d cm=%0b actual c=%0b op=%h expected c=%0b op=%h",
               tag, k, fromReg, ia, ra, cm, carryOut, opOut, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] regPick [0:7];
    regPick[0] = 8'd0;  regPick[1] = 8'd31; regPick[2] = 8'd32; regPick[3] = 8'd33;
    regPick[4] = 8'd64; regPick[5] = 8'd96; regPick[6] = 8'd255; regPick[7] = 8'd1;
    void'($urandom(32'd20240611));

    // Reset state: all inputs zero, default immediate left shift by 0 (R2)
    @(negedge clk);
    checks++;
    if (opOut !== 32'd0 || carryOut !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle: actual c=%0b op=%h expected c=0 op=00000000", carryOut, opOut);
    end

    // Directed corner cases
    runOne(32'h8000_0001, 2'd0, 1'b0, 5'd1,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R1");
    runOne(32'h8000_0001, 2'd0, 1'b0, 5'd31, 8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R1");
    runOne(32'h8000_0001, 2'd0, 1'b0, 5'd0,  8'd0, 1'b1, 1'b0, 8'h00, 4'd0, "R2");
    runOne(32'h8000_0000, 2'd1, 1'b0, 5'd0,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R3");
    runOne(32'hF000_000F, 2'd1, 1'b0, 5'd4,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R3");
    runOne(32'h8000_0000, 2'd2, 1'b0, 5'd0,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R4");
    runOne(32'h7FFF_FFFF, 2'd2, 1'b0, 5'd0,  8'd0, 1'b1, 1'b0, 8'h00, 4'd0, "R4");
    runOne(32'h8000_0010, 2'd2, 1'b0, 5'd5,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R4");
    runOne(32'h0000_00F1, 2'd3, 1'b0, 5'd4,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R5");
    runOne(32'h0000_0001, 2'd3, 1'b0, 5'd0,  8'd0, 1'b1, 1'b0, 8'h00, 4'd0, "R6");
    runOne(32'hFFFF_FFFE, 2'd3, 1'b0, 5'd0,  8'd0, 1'b0, 1'b0, 8'h00, 4'd0, "R6");
    for (int k = 0; k < 4; k++)
      runOne(32'hA5A5_5A5A, 2'(k), 1'b1, 5'd7, 8'd0, 1'b1, 1'b0, 8'h00, 4'd0, "R7");
    runOne(32'h0000_0001, 2'd0, 1'b1, 5'd3, 8'd32,  1'b0, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'h8000_0000, 2'd1, 1'b1, 5'd3, 8'd32,  1'b0, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'hFFFF_FFFF, 2'd1, 1'b1, 5'd3, 8'd33,  1'b1, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'hFFFF_FFFF, 2'd0, 1'b1, 5'd3, 8'd200, 1'b1, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'h8000_0000, 2'd2, 1'b1, 5'd3, 8'd255, 1'b0, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'h8000_0000, 2'd3, 1'b1, 5'd3, 8'd64,  1'b0, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'h0000_0003, 2'd3, 1'b1, 5'd3, 8'd34,  1'b0, 1'b0, 8'h00, 4'd0, "R8");
    runOne(32'h1234_5678, 2'd1, 1'b0, 5'd9, 8'd0, 1'b1, 1'b1, 8'hFF, 4'd4, "R9");
    runOne(32'h1234_5678, 2'd2, 1'b1, 5'd9, 8'd7, 1'b0, 1'b1, 8'h03, 4'd1, "R9");
    runOne(32'hFFFF_FFFF, 2'd0, 1'b0, 5'd0, 8'd0, 1'b1, 1'b1, 8'h80, 4'd0, "R9");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x;
      logic [1:0]  k;
      logic        fr, cin, cm;
      logic [4:0]  ia;
      logic [7:0]  ra, cv;
      logic [3:0]  cr;
      x   = $urandom();
      if ($urandom_range(0, 7) == 0) x = {x[31], 31'd0} | 32'd1;
      k   = 2'($urandom_range(0, 3));
      fr  = 1'($urandom_range(0, 1));
      cin = 1'($urandom_range(0, 1));
      cm  = ($urandom_range(0, 4) == 0);
      ia  = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom());
      ra  = ($urandom_range(0, 1) == 0) ? regPick[$urandom_range(0, 7)] : 8'($urandom());
      cv  = 8'($urandom());
      cr  = 4'($urandom());
      runOne(x, k, fr, ia, ra, cin, cm, cv, cr, reqOf(k, fr, ia, ra, cm));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule